// File: doc/BRIEF.md
# Configurable Product-Term Logic Block

This block is a small programmable sum-of-products array of the kind found inside a complex programmable logic device. Thirty-six data inputs enter the array, and each one supplies a true literal and a complement literal. For every one of 83 product terms, a configuration bit per literal decides whether that literal joins the term's AND. A term that has its enable bit clear is forced low. The first 80 terms form 16 groups of five adjacent terms. Group `s` owns terms `5s` to `5s+4` and feeds output slice `s`. The three remaining terms are shared controls: term 80 is the slice clock, term 81 is the slice clear, and term 82 is the output enable.

Each slice ORs its five terms. A per-slice mode bit then selects either the combinational sum or a flip-flop that captures the sum on the rising edge of the shared clock term. The clock term and the clear term each pass through a configurable inverter first. The output-enable term drives one enable per slice, which the pad cell outside this block uses to float its pin.

All configuration bits sit in one shift chain. The chain loads serially while `cfg_load_i` is high, and every slice flip-flop stays cleared for as long as loading continues.

Top module: `pterm_block`

## Requirements
- R1: Each clock edge with `cfg_load_i` high shifts `cfg_din_i` into configuration bit 0 and moves every bit one place toward the higher index, so the first of 6077 shifted bits ends in bit 6076. With `cfg_load_i` low, the configuration does not change.
- R2: Product term p uses configuration bits `73p` to `73p+72`. Bit `73p+2k` connects the true form of input k. Bit `73p+2k+1` connects its complement. Bit `73p+72` enables the term. An enabled term is the AND of its connected literals.
- R3: A term whose enable bit is 0 gives 0, whatever its connection bits are.
- R4: An enabled term with no connected literals gives 1. An enabled term that connects both forms of the same input gives 0.
- R5: When its mode bit is 0, slice s outputs the OR of terms `5s` to `5s+4`.
- R6: When its mode bit is 1, slice s outputs a flip-flop value. The flip-flop loads the slice's OR on each rising edge of term 80 XOR the clock-inversion bit, and holds at all other times. The mode bit of slice s is configuration bit `6059+s`. The clock-inversion bit is bit 6075.
- R7: While term 81 XOR the clear-inversion bit (bit 6076) is 1, every slice flip-flop is cleared at once, without waiting for a clock edge.
- R8: Term 82 drives all 16 bits of `slice_oe_o`.
- R9: While `cfg_load_i` is high, all slice flip-flops are held cleared, so a registered slice reads 0 right after a reload.
- R10: After reset, the whole configuration is 0, so every output and every output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Shift enable for the configuration chain; also holds the slice flip-flops cleared |
| cfg_din_i | input | 1 | Serial configuration data |
| data_i | input | 36 | Array inputs |
| slice_o | output | 16 | Slice outputs |
| slice_oe_o | output | 16 | Per-slice output enable for the pad cell |

## Verification
A configuration bit that lands in the wrong place changes the output of the slice that owns the affected term. Because every term is combinational, the change shows within the same input pattern, as soon as that pattern makes the term's literals decisive. A flip-flop that misses a clock edge, a clear or a reload shows its stale value at once. The bench therefore compares a registered slice immediately after each edge of the clock term, each edge of the clear term and each reload.

// File: rtl/plb_pkg.sv
package plb_pkg;
  localparam int unsigned N_SHARED = 3;
  typedef enum int unsigned {
    SH_CLK  = 0,
    SH_INIT = 1,
    SH_OE   = 2
  } shared_pt_e;
endpackage

// File: rtl/plb_cfg_chain.sv
module plb_cfg_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         din_i,
  output logic [W-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_o <= '0;
    else if (load_i) cfg_o <= {cfg_o[W-2:0], din_i};
  end
endmodule

// File: rtl/plb_pt_array.sv
module plb_pt_array #(
  parameter int unsigned N_IN = 36,
  parameter int unsigned N_PT = 83,
  localparam int unsigned N_LINE = 2 * N_IN,
  localparam int unsigned PT_W   = N_LINE + 1
) (
  input  logic [N_IN-1:0]      in_i,
  input  logic [N_PT*PT_W-1:0] cfg_i,
  output logic [N_PT-1:0]      pt_o
);
  logic [N_LINE-1:0] lines;

  for (genvar k = 0; k < N_IN; k++) begin : g_line
    assign lines[2*k]   = in_i[k];
    assign lines[2*k+1] = ~in_i[k];
  end

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    logic [N_LINE-1:0] conn;
    logic              en;
    assign conn    = cfg_i[p*PT_W +: N_LINE];
    assign en      = cfg_i[p*PT_W + N_LINE];
    // unconnected lines read as 1 in the wired-AND
    assign pt_o[p] = en & (&(lines | ~conn));
  end
endmodule

// File: rtl/plb_slice.sv
module plb_slice #(
  parameter int unsigned CL = 5
) (
  input  logic          sclk_i,
  input  logic          clr_i,
  input  logic [CL-1:0] terms_i,
  input  logic          reg_sel_i,
  output logic          val_o
);
  logic sum, q;

  assign sum = |terms_i;

  always_ff @(posedge sclk_i or posedge clr_i) begin
    if (clr_i) q <= 1'b0;
    else       q <= sum;
  end

  assign val_o = reg_sel_i ? q : sum;
endmodule

// File: rtl/pterm_block.sv
module pterm_block #(
  parameter int unsigned N_IN    = 36,
  parameter int unsigned N_SLICE = 16,
  parameter int unsigned CL_SIZE = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_load_i,
  input  logic               cfg_din_i,
  input  logic [N_IN-1:0]    data_i,
  output logic [N_SLICE-1:0] slice_o,
  output logic [N_SLICE-1:0] slice_oe_o
);
  import plb_pkg::*;

  localparam int unsigned N_LINE  = 2 * N_IN;
  localparam int unsigned PT_W    = N_LINE + 1;
  localparam int unsigned N_LPT   = N_SLICE * CL_SIZE;
  localparam int unsigned N_PT    = N_LPT + N_SHARED;
  localparam int unsigned PT_BITS = N_PT * PT_W;
  localparam int unsigned SEL_OFS = PT_BITS;
  localparam int unsigned CKI_OFS = SEL_OFS + N_SLICE;
  localparam int unsigned INI_OFS = CKI_OFS + 1;
  localparam int unsigned CFG_W   = INI_OFS + 1;
  localparam int unsigned PT_CLK  = N_LPT + int'(SH_CLK);
  localparam int unsigned PT_INIT = N_LPT + int'(SH_INIT);
  localparam int unsigned PT_OE   = N_LPT + int'(SH_OE);

  logic [CFG_W-1:0]   cfg_q;
  logic [N_PT-1:0]    pt;
  logic [N_SLICE-1:0] reg_sel;
  logic               sclk, init_eff, slice_clr;

  plb_cfg_chain #(.W(CFG_W)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load_i),
    .din_i  (cfg_din_i),
    .cfg_o  (cfg_q)
  );

  plb_pt_array #(.N_IN(N_IN), .N_PT(N_PT)) u_array (
    .in_i  (data_i),
    .cfg_i (cfg_q[PT_BITS-1:0]),
    .pt_o  (pt)
  );

  assign reg_sel   = cfg_q[SEL_OFS +: N_SLICE];
  assign sclk      = pt[PT_CLK] ^ cfg_q[CKI_OFS];
  assign init_eff  = pt[PT_INIT] ^ cfg_q[INI_OFS];
  assign slice_clr = ~rst_ni | cfg_load_i | init_eff;

  for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
    plb_slice #(.CL(CL_SIZE)) u_slice (
      .sclk_i    (sclk),
      .clr_i     (slice_clr),
      .terms_i   (pt[s*CL_SIZE +: CL_SIZE]),
      .reg_sel_i (reg_sel[s]),
      .val_o     (slice_o[s])
    );
  end

  assign slice_oe_o = {N_SLICE{pt[PT_OE]}};

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_load_i |=> $stable(cfg_q));

  p_shift_in_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> cfg_q[0] == $past(cfg_din_i));

  p_load_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |-> (slice_o & reg_sel) == '0);

  p_init_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_eff |-> (slice_o & reg_sel) == '0);
endmodule

// File: tb/pterm_block_tb.sv
module pterm_block_tb;
  localparam int N_IN = 36, N_SLICE = 16, CL = 5;
  localparam int N_LINE = 72, PT_W = 73, N_PT = 83;
  localparam int SEL_OFS = N_PT * PT_W;
  localparam int CKI_OFS = SEL_OFS + N_SLICE;
  localparam int INI_OFS = CKI_OFS + 1;
  localparam int CFG_W = INI_OFS + 1;

  logic clk = 1'b0, rst_ni = 1'b0, cfg_load = 1'b0, cfg_din = 1'b0;
  logic [N_IN-1:0] data = '0;
  logic [N_SLICE-1:0] slice_o, slice_oe;
  logic [CFG_W-1:0] cv;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pterm_block u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_load_i(cfg_load), .cfg_din_i(cfg_din),
    .data_i(data), .slice_o(slice_o), .slice_oe_o(slice_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic conn(int p, int line);
    cv[p*PT_W + line] = 1'b1;
  endtask

  task automatic en(int p);
    cv[p*PT_W + N_LINE] = 1'b1;
  endtask

  task automatic load_cfg();
    for (int i = CFG_W - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_din  = cv[i];
    end
    @(negedge clk);
    cfg_load = 1'b0;
    #1;
  endtask

  function automatic logic pt_val(int p);
    logic r = cv[p*PT_W + N_LINE];
    for (int k = 0; k < N_IN; k++) begin
      if (cv[p*PT_W + 2*k] && !data[k]) r = 1'b0;
      if (cv[p*PT_W + 2*k + 1] && data[k]) r = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [N_SLICE-1:0] exp_comb();
    logic [N_SLICE-1:0] r = '0;
    for (int s = 0; s < N_SLICE; s++)
      for (int j = 0; j < CL; j++) r[s] |= pt_val(s*CL + j);
    return r;
  endfunction

  task automatic set_d(logic [N_IN-1:0] v);
    @(negedge clk);
    data = v;
    #1;
  endtask

  task automatic build_reg(bit inv);
    cv = '0;
    for (int s = 0; s < N_SLICE; s++) begin
      en(s*CL); conn(s*CL, 2*s);
      cv[SEL_OFS + s] = 1'b1;
    end
    en(80); conn(80, 2*35);
    en(81); conn(81, 2*34);
    en(82); conn(82, 2*32 + 1);
    cv[CKI_OFS] = inv;
    cv[INI_OFS] = inv;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R10 reset state
    chk("R10 out", 32'(slice_o), 0);
    chk("R10 oe", 32'(slice_oe), 0);

    // Config A: varied combinational sums, R1 R2 R5
    cv = '0;
    for (int s = 0; s < N_SLICE; s++)
      for (int j = 0; j < CL; j++)
        if (j <= s % CL) begin
          en(s*CL + j);
          conn(s*CL + j, 2*((s + j) % N_IN));
          conn(s*CL + j, 2*((s + 2*j + 7) % N_IN) + 1);
        end
    en(82);
    load_cfg();
    chk("R8 oe on", 32'(slice_oe), 32'hffff);
    for (int v = 0; v < 200; v++) begin
      set_d({$urandom, $urandom});
      chk("R1 R2 R5 comb", 32'(slice_o), 32'(exp_comb()));
    end

    // Config B: disabled / empty / contradictory terms, R3 R4
    cv = '0;
    for (int p = 0; p < 80; p++)
      for (int l = 0; l < N_LINE; l++) conn(p, l);
    for (int l = 0; l < N_LINE; l++) cv[17*PT_W + l] = 1'b0;
    en(17);
    en(26);
    en(82);
    load_cfg();
    for (int v = 0; v < 20; v++) begin
      set_d({$urandom, $urandom});
      chk("R3 R4 terms", 32'(slice_o), 32'h0008);
    end

    // Config C: registered slices, R6 R7 R8 R9
    build_reg(1'b0);
    set_d('0);
    load_cfg();
    chk("R9 after load", 32'(slice_o), 0);
    set_d(36'h0_0000_a5c3);
    chk("R6 no edge", 32'(slice_o), 0);
    set_d(36'h8_0000_a5c3);
    chk("R6 rise", 32'(slice_o), 32'ha5c3);
    set_d(36'h8_0000_0f0f);
    chk("R6 hold high", 32'(slice_o), 32'ha5c3);
    set_d(36'h0_0000_0f0f);
    chk("R6 fall", 32'(slice_o), 32'ha5c3);
    set_d(36'h8_0000_0f0f);
    chk("R6 rise2", 32'(slice_o), 32'h0f0f);
    set_d(36'hc_0000_0f0f);
    chk("R7 clear", 32'(slice_o), 0);
    set_d(36'h8_0000_0f0f);
    chk("R7 stays", 32'(slice_o), 0);
    set_d(36'h0_0000_0f0f);
    set_d(36'h8_0000_0f0f);
    chk("R6 recapture", 32'(slice_o), 32'h0f0f);
    set_d(36'h9_0000_0f0f);
    chk("R8 oe off", 32'(slice_oe), 0);
    set_d(36'h8_0000_0f0f);
    chk("R8 oe back", 32'(slice_oe), 32'hffff);
    set_d(36'h0_0000_ffff);
    chk("R6 before reload", 32'(slice_o), 32'h0f0f);
    load_cfg();
    chk("R9 reload clears", 32'(slice_o), 0);

    // Config D: inverted clock and clear, R6 R7
    build_reg(1'b1);
    set_d(36'hc_0000_1234);
    load_cfg();
    chk("R9 after load D", 32'(slice_o), 0);
    set_d(36'h4_0000_1234);
    chk("R6 inv edge", 32'(slice_o), 32'h1234);
    set_d(36'hc_0000_1234);
    chk("R6 inv no edge", 32'(slice_o), 32'h1234);
    set_d(36'h8_0000_1234);
    chk("R7 inv clear", 32'(slice_o), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule